// File: doc/BRIEF.md
# Next-PC Selection Unit

This block holds the program counter of a fixed-width instruction fetch path and picks, on every rising clock edge, the address it loads next. The candidates are the sequential address (current PC plus the instruction width), a PC-relative target, an absolute target carried with the instruction, a target taken from a register or ALU value, and a fixed trap vector. An asynchronous reset forces a boot address.

A 3-bit flow code says what the instruction in flight does. Conditional relative branches test one of four flags against a chosen polarity. A selected target that is not aligned to the instruction width is refused: the PC holds and a one-cycle fault pulse is raised. Decode, flag generation and instruction memory sit outside the block.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` equals `BOOT_ADDR` and `fault_o` is 0, taking effect without waiting for a clock edge.
- R2: With `trap_i` low and `kind_i` equal to 0 (sequential) or to any of the unused codes 5, 6 and 7, the next edge loads `pc_o + INSTR_W`, wrapping modulo 2^`ADDR_W`.
- R3: Flow code 1 (relative jump) loads `pc_o` plus `imm_i`, the immediate read as a two's-complement offset, wrapping modulo 2^`ADDR_W`.
- R4: Flow code 2 (absolute jump) loads `imm_i`; flow code 3 (indirect jump) loads `reg_i`.
- R5: Flow code 4 (conditional relative branch) tests the flag picked by `cond_i[1:0]` (0 zero = `flags_i[0]`, 1 carry = `flags_i[1]`, 2 sign = `flags_i[2]`, 3 overflow = `flags_i[3]`); with `cond_i[2]` = 0 it is taken when that flag is 1, with `cond_i[2]` = 1 when it is 0. Taken loads `pc_o + imm_i`, otherwise `pc_o + INSTR_W`.
- R6: A high `trap_i` loads `TRAP_ADDR` whatever the flow code, condition and targets, and never raises a fault.
- R7: When the target chosen by flow codes 1–4 (taken) has any of its low log2(`INSTR_W`) bits set, `pc_o` keeps its value and `fault_o` is 1 for the following cycle only, returning to 0 after the next aligned or sequential step.
- R8: Sequential steps, untaken branches and aligned targets leave `fault_o` at 0, even when `imm_i` or `reg_i` hold misaligned values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the PC changes only on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset to the boot address |
| kind_i | input | 3 | Flow code: 0 seq, 1 rel jump, 2 abs jump, 3 indirect jump, 4 cond rel branch, 5–7 seq |
| cond_i | input | 3 | [1:0] flag index, [2] take-on-clear polarity |
| flags_i | input | 4 | {overflow, sign, carry, zero} |
| imm_i | input | ADDR_W | Signed offset (codes 1, 4) or absolute address (code 2) |
| reg_i | input | ADDR_W | Indirect target (code 3) |
| trap_i | input | 1 | Trap request, overrides the flow code |
| pc_o | output | ADDR_W | Current program counter |
| fault_o | output | 1 | One-cycle misalignment fault pulse |

## Verification
The assertions assume `TRAP_ADDR` and `BOOT_ADDR` are aligned to `INSTR_W`, that `INSTR_W` is a power of two, and that inputs are stable around the rising edge. The stimulus changes inputs only on falling edges, loads every starting PC through an aligned absolute jump, and uses offsets and register values that are multiples of the width except in the sweep that deliberately sets the low bits to probe the fault path.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam logic [2:0] FLOW_SEQ  = 3'd0;
  localparam logic [2:0] FLOW_JREL = 3'd1;
  localparam logic [2:0] FLOW_JABS = 3'd2;
  localparam logic [2:0] FLOW_JREG = 3'd3;
  localparam logic [2:0] FLOW_BREL = 3'd4;

  typedef enum logic [2:0] {
    SRC_SEQ  = 3'd0,
    SRC_REL  = 3'd1,
    SRC_ABS  = 3'd2,
    SRC_REG  = 3'd3,
    SRC_TRAP = 3'd5
  } src_e;
endpackage

// File: rtl/pc_cond_eval.sv
module pc_cond_eval (
  input  logic [3:0] flags_i,
  input  logic [2:0] cond_i,
  output logic       hit_o
);
  // cond_i[2] inverts: take on clear flag
  assign hit_o = flags_i[cond_i[1:0]] ^ cond_i[2];
endmodule

// File: rtl/pc_src_sel.sv
module pc_src_sel
  import pc_pkg::*;
(
  input  logic [2:0] kind_i,
  input  logic       hit_i,
  input  logic       trap_i,
  output src_e       src_o
);
  always_comb begin
    if (trap_i) begin
      src_o = SRC_TRAP;
    end else begin
      unique case (kind_i)
        FLOW_JREL: src_o = SRC_REL;
        FLOW_JABS: src_o = SRC_ABS;
        FLOW_JREG: src_o = SRC_REG;
        FLOW_BREL: src_o = hit_i ? SRC_REL : SRC_SEQ;
        default:   src_o = SRC_SEQ;
      endcase
    end
  end
endmodule

// File: rtl/pc_align_chk.sv
module pc_align_chk #(
  parameter int ADDR_W  = 8,
  parameter int INSTR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              bad_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(INSTR_W - 1);

  generate
    if (INSTR_W > 1) begin : g_check
      assign bad_o = |(addr_i & LOW_MASK);
    end else begin : g_none
      logic [ADDR_W-1:0] unused_addr;
      assign unused_addr = addr_i;
      assign bad_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pc_pkg::*;
#(
  parameter int               ADDR_W    = 8,
  parameter int               INSTR_W   = 4,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0,
  parameter logic [ADDR_W-1:0] TRAP_ADDR = ADDR_W'(16)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        kind_i,
  input  logic [2:0]        cond_i,
  input  logic [3:0]        flags_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic              trap_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              fault_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_W);

  logic [ADDR_W-1:0] pc_q, cand, seq_addr, rel_addr;
  logic              fault_q, hit, cand_bad, hold;
  src_e              src;

  assign seq_addr = pc_q + STEP;
  assign rel_addr = pc_q + imm_i;  // wraps like a signed add

  pc_cond_eval u_cond (
    .flags_i (flags_i),
    .cond_i  (cond_i),
    .hit_o   (hit)
  );

  pc_src_sel u_sel (
    .kind_i  (kind_i),
    .hit_i   (hit),
    .trap_i  (trap_i),
    .src_o   (src)
  );

  always_comb begin
    unique case (src)
      SRC_REL:  cand = rel_addr;
      SRC_ABS:  cand = imm_i;
      SRC_REG:  cand = reg_i;
      SRC_TRAP: cand = TRAP_ADDR;
      default:  cand = seq_addr;
    endcase
  end

  pc_align_chk #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_align (
    .addr_i (cand),
    .bad_o  (cand_bad)
  );

  // seq and trap paths are aligned by construction of the parameters
  assign hold = cand_bad && (src != SRC_SEQ) && (src != SRC_TRAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= BOOT_ADDR;
      fault_q <= 1'b0;
    end else begin
      if (!hold) pc_q <= cand;
      fault_q <= hold;
    end
  end

  assign pc_o    = pc_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk #(
  parameter int               ADDR_W    = 8,
  parameter int               INSTR_W   = 4,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0,
  parameter logic [ADDR_W-1:0] TRAP_ADDR = ADDR_W'(16)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        kind_i,
  input logic [ADDR_W-1:0] imm_i,
  input logic              trap_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic              fault_o
);
  localparam logic [ADDR_W-1:0] MASK = ADDR_W'(INSTR_W - 1);

  logic is_seq, is_abs, imm_ok;
  assign is_seq = (kind_i == 3'd0) || (kind_i > 3'd4);
  assign is_abs = (kind_i == 3'd2);
  assign imm_ok = (imm_i & MASK) == '0;

  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      boot_hold_chk: assert (pc_o == BOOT_ADDR && !fault_o);
    end
  end

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_i && is_seq) |=> (pc_o == $past(pc_o) + ADDR_W'(INSTR_W)));

  // R4
  abs_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_i && is_abs && imm_ok) |=> (pc_o == $past(imm_i)));

  // R6
  trap_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (pc_o == TRAP_ADDR && !fault_o));

  // R7
  misalign_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_i && is_abs && !imm_ok) |=> ($stable(pc_o) && fault_o));

  // R8
  seq_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_i && is_seq) |=> !fault_o);
endmodule

bind pc_next_unit pc_next_unit_chk #(
  .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .BOOT_ADDR(BOOT_ADDR), .TRAP_ADDR(TRAP_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .kind_i(kind_i), .imm_i(imm_i),
  .trap_i(trap_i), .pc_o(pc_o), .fault_o(fault_o)
);

// File: tb/pc_next_unit_test.sv
module pc_next_unit_test;
  localparam int        AW   = 8;
  localparam int        IW   = 4;
  localparam logic [7:0] BOOT = 8'h20;
  localparam logic [7:0] TRAP = 8'hC0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] kind = '0, cond = '0;
  logic [3:0] flags = '0;
  logic [7:0] imm = '0, regv = '0;
  logic       trap = 1'b0;
  logic [7:0] pc;
  logic       fault;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pc_next_unit #(.ADDR_W(AW), .INSTR_W(IW), .BOOT_ADDR(BOOT), .TRAP_ADDR(TRAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .kind_i(kind), .cond_i(cond), .flags_i(flags),
    .imm_i(imm), .reg_i(regv), .trap_i(trap), .pc_o(pc), .fault_o(fault)
  );

  task automatic chk(input string req, input logic [7:0] act_pc, input logic [7:0] exp_pc,
                     input logic act_f, input logic exp_f);
    total++;
    if (act_pc !== exp_pc || act_f !== exp_f) begin
      bad++;
      $display("FAIL %s pc=%h/fault=%b expected pc=%h/fault=%b", req, act_pc, act_f, exp_pc, exp_f);
    end
  endtask

  // drive at falling edge, one rising edge, return at next falling edge
  task automatic step(input logic [2:0] k, input logic [2:0] c, input logic [3:0] f,
                      input logic [7:0] im, input logic [7:0] rv, input logic t);
    kind = k; cond = c; flags = f; imm = im; regv = rv; trap = t;
    @(negedge clk);
  endtask

  task automatic load(input logic [7:0] a);
    step(3'd2, 3'd0, 4'd0, a, 8'h00, 1'b0);
    chk("R4 abs load", pc, a, fault, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog pc=%h expected completion", pc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 reset", pc, BOOT, fault, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 first step", pc, BOOT + 8'd4, fault, 1'b0);

    // sweep flow code x condition x flags
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < 8; c++) begin
        for (int f = 0; f < 16; f++) begin
          logic [7:0] base, off, rv, exp;
          logic       take;
          base = 8'(k * 32 + f * 4);
          off  = 8'(c * 4) - 8'd12;
          rv   = 8'(f * 8 + 4);
          take = f[c[1:0]] ^ c[2];
          load(base);
          case (k)
            1:       exp = base + off;
            2:       exp = off;
            3:       exp = rv;
            4:       exp = take ? base + off : base + 8'd4;
            default: exp = base + 8'd4;
          endcase
          step(3'(k), 3'(c), 4'(f), off, rv, 1'b0);
          case (k)
            1: chk("R3 rel jump", pc, exp, fault, 1'b0);
            2: chk("R4 abs jump", pc, exp, fault, 1'b0);
            3: chk("R4 reg jump", pc, exp, fault, 1'b0);
            4: chk("R5 cond branch", pc, exp, fault, 1'b0);
            default: chk("R2 sequential", pc, exp, fault, 1'b0);
          endcase
        end
      end
    end

    // misaligned targets
    for (int lb = 1; lb < 4; lb++) begin
      for (int k = 1; k < 5; k++) begin
        load(8'h40);
        step(3'(k), 3'b000, 4'b0001, 8'h10 | 8'(lb), 8'h30 | 8'(lb), 1'b0);
        chk("R7 misaligned hold", pc, 8'h40, fault, 1'b1);
        step(3'd0, 3'd0, 4'd0, 8'h00, 8'h00, 1'b0);
        chk("R7 fault pulse ends", pc, 8'h44, fault, 1'b0);
      end
      load(8'h50);
      step(3'd4, 3'b100, 4'b0001, 8'h10 | 8'(lb), 8'h00, 1'b0);
      chk("R8 untaken misaligned", pc, 8'h54, fault, 1'b0);
      step(3'd0, 3'd0, 4'd0, 8'h03, 8'h07, 1'b0);
      chk("R8 seq misaligned imm", pc, 8'h58, fault, 1'b0);
    end

    // trap over every flow code, misaligned operands
    for (int k = 0; k < 8; k++) begin
      load(8'h60);
      step(3'd2, 3'd0, 4'd0, 8'h61, 8'h00, 1'b0);
      chk("R7 fault before trap", pc, 8'h60, fault, 1'b1);
      step(3'(k), 3'b000, 4'b0001, 8'h13, 8'h27, 1'b1);
      chk("R6 trap priority", pc, TRAP, fault, 1'b0);
    end

    // wrap cases
    load(8'hFC);
    step(3'd0, 3'd0, 4'd0, 8'h00, 8'h00, 1'b0);
    chk("R2 wrap", pc, 8'h00, fault, 1'b0);
    load(8'h04);
    step(3'd1, 3'd0, 4'd0, 8'hF0, 8'h00, 1'b0);
    chk("R3 negative wrap", pc, 8'hF4, fault, 1'b0);

    // asynchronous reset mid-run with a fault pending
    load(8'h80);
    step(3'd3, 3'd0, 4'd0, 8'h00, 8'h81, 1'b0);
    chk("R7 reg misaligned", pc, 8'h80, fault, 1'b1);
    #3 rst_n = 1'b0;
    #2 chk("R1 async reset", pc, BOOT, fault, 1'b0);
    @(negedge clk);
    chk("R1 reset held", pc, BOOT, fault, 1'b0);
    rst_n = 1'b1;
    step(3'd0, 3'd0, 4'd0, 8'h00, 8'h00, 1'b0);
    chk("R2 after reset", pc, BOOT + 8'd4, fault, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule